// File: doc/BRIEF.md
# Streaming Symmetric Low-Pass FIR Filter

This block is a fixed low-pass filter with 27 taps that sits in a streaming datapath. Samples arrive on a valid/ready input stream and leave on a valid/ready output stream. When the input is valid and the output side is not stalled, the block takes one 32-bit two's-complement sample on every clock. Each output is the full-precision sum of the 27 most recent accepted samples, each weighted by a built-in integer coefficient. That sum is rounded to 32 bits and clipped to the signed 32-bit range.

The coefficient set is mirror-symmetric about the centre tap. The block uses this by adding each pair of mirrored samples first, so each output needs 14 multiplies instead of 27. A packet-end flag can travel with any input sample. It leaves on the output word that the same sample produced. When the downstream consumer drops ready, the whole pipeline freezes and input ready falls in the same cycle, so no sample is lost or repeated.

Top module: `fir_sym_stream`

## Requirements
- R1: After reset, m_tvalid is low, and the sample history is all zero. The first outputs after reset therefore contain no contribution from samples older than the first accepted one.
- R2: While m_tready stays high, s_tready stays high on every cycle, so one sample per clock is sustained.
- R3: Each output equals round((sum over k=0..26 of c[k]·x[n−k]) / 65536), where x[n] is the newest accepted sample and c is (−255, −260, −312, −288, −144, 153, 616, 1233, 1963, 2739, 3474, 4081, 4481, 4620), mirrored about the 4620 centre. Samples, coefficients and the output are signed two's complement. A value above 2^31−1 is clipped to 2^31−1, and a value below −2^31 is clipped to −2^31.
- R4: Rounding adds 32768 to the full-precision sum before dropping its 16 low bits. An exact half therefore goes toward positive infinity: −127.5 becomes −127 and 76.5 becomes 77.
- R5: With no stall, the result of a sample accepted on a clock edge is presented with m_tvalid high after the fourth following clock edge.
- R6: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R7: m_tlast is high on exactly the output word produced by an input sample accepted with s_tlast high, and m_tlast is never high while m_tvalid is low.
- R8: s_tready is high exactly when m_tvalid is low or m_tready is high.
- R9: The block produces one output per accepted sample, in order. It never presents an output that no accepted sample produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tvalid | input | 1 | Input sample valid |
| s_tdata | input | 32 | Input sample, signed |
| s_tlast | input | 1 | Packet-end flag of the input sample |
| s_tready | output | 1 | Block can accept a sample this cycle |
| m_tvalid | output | 1 | Output sample valid |
| m_tdata | output | 32 | Filtered sample, signed, rounded and clipped |
| m_tlast | output | 1 | Packet-end flag of the output sample |
| m_tready | input | 1 | Consumer takes the output sample this cycle |

## Verification
The in-design properties assume two things about the inputs. First, s_tdata and s_tlast matter only in cycles where s_tvalid and s_tready are both high. Second, fewer than 65536 samples are in flight at once, because the check on unmatched outputs compares wrapping 16-bit acceptance and delivery counts. The stimulus respects both limits: it randomises data freely on idle cycles, and the pipeline never holds more than a handful of samples. m_tready may change on any cycle. The bench toggles it randomly and also holds it low for long stretches while input stays valid, so that the freeze and the input-ready rule are both exercised.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

  localparam int NTAPS  = 27;
  localparam int NPAIR  = (NTAPS + 1) / 2;
  localparam int COEF_W = 16;

  // Half of the symmetric weight set; index beyond the centre mirrors back.
  function automatic logic signed [COEF_W-1:0] coef(input int idx);
    int h;
    h = (idx < NPAIR) ? idx : (NTAPS - 1 - idx);
    case (h)
      0:  return COEF_W'(-255);
      1:  return COEF_W'(-260);
      2:  return COEF_W'(-312);
      3:  return COEF_W'(-288);
      4:  return COEF_W'(-144);
      5:  return COEF_W'(153);
      6:  return COEF_W'(616);
      7:  return COEF_W'(1233);
      8:  return COEF_W'(1963);
      9:  return COEF_W'(2739);
      10: return COEF_W'(3474);
      11: return COEF_W'(4081);
      12: return COEF_W'(4481);
      13: return COEF_W'(4620);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/fir_sym_taps.sv
module fir_sym_taps #(
  parameter int DATA_W = 32,
  parameter int NTAPS  = 27
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic                     in_fire,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     in_last,
  output logic signed [DATA_W-1:0] taps [NTAPS],
  output logic                     out_v,
  output logic                     out_last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
      out_v    <= 1'b0;
      out_last <= 1'b0;
    end else if (adv) begin
      out_v    <= in_fire;
      out_last <= in_fire && in_last;
      if (in_fire) begin
        for (int k = NTAPS - 1; k > 0; k--) taps[k] <= taps[k-1];
        taps[0] <= in_data;
      end
    end
  end

  // History moves by exactly one position per accepted sample.
  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> (taps[1] == $past(taps[0])) && (taps[0] == $past(in_data)));

  // A frozen pipeline keeps its history untouched.
  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(taps[0]) && $stable(out_v));

endmodule

// File: rtl/fir_sym_preadd.sv
module fir_sym_preadd #(
  parameter int DATA_W = 32,
  parameter int NTAPS  = 27,
  parameter int NPAIR  = 14,
  parameter int PAIR_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic signed [DATA_W-1:0] taps [NTAPS],
  input  logic                     in_v,
  input  logic                     in_last,
  output logic signed [PAIR_W-1:0] pair [NPAIR],
  output logic                     out_v,
  output logic                     out_last
);

  logic signed [PAIR_W-1:0] pair_nxt [NPAIR];

  // Mirrored samples share a weight, so they are summed before the multiply.
  always_comb begin
    for (int k = 0; k < NPAIR; k++) begin
      if (k == NTAPS - 1 - k)
        pair_nxt[k] = PAIR_W'(taps[k]);
      else
        pair_nxt[k] = PAIR_W'(taps[k]) + PAIR_W'(taps[NTAPS-1-k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPAIR; k++) pair[k] <= '0;
      out_v    <= 1'b0;
      out_last <= 1'b0;
    end else if (adv) begin
      for (int k = 0; k < NPAIR; k++) pair[k] <= pair_nxt[k];
      out_v    <= in_v;
      out_last <= in_last;
    end
  end

  p_last_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_v);

endmodule

// File: rtl/fir_sym_mac.sv
module fir_sym_mac #(
  parameter int PAIR_W = 33,
  parameter int NPAIR  = 14,
  parameter int ACC_W  = 50,
  parameter int DROP_W = 16,
  parameter int OUT_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic signed [PAIR_W-1:0] pair [NPAIR],
  input  logic                     in_v,
  input  logic                     in_last,
  input  logic                     m_tready,
  output logic signed [OUT_W-1:0]  m_tdata,
  output logic                     m_tvalid,
  output logic                     m_tlast
);

  localparam int COEF_W = fir_sym_pkg::COEF_W;
  localparam int SH_W   = ACC_W + 1 - DROP_W;
  localparam logic [ACC_W:0] HALF = (ACC_W+1)'(1) << (DROP_W - 1);

  // Round half toward +inf, drop DROP_W bits, clip to OUT_W signed.
  function automatic logic signed [OUT_W-1:0] round_clip(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W:0]  t;
    logic signed [SH_W-1:0] s;
    t = {a[ACC_W-1], a} + HALF;
    s = t[ACC_W:DROP_W];
    if (s[SH_W-1:OUT_W-1] == '0 || s[SH_W-1:OUT_W-1] == '1)
      return s[OUT_W-1:0];
    else if (s[SH_W-1])
      return {1'b1, {(OUT_W-1){1'b0}}};
    else
      return {1'b0, {(OUT_W-1){1'b1}}};
  endfunction

  logic signed [ACC_W-1:0] term [NPAIR];
  logic signed [ACC_W-1:0] prod [NPAIR];
  logic signed [ACC_W-1:0] sum_nxt;
  logic signed [ACC_W-1:0] sum_q;
  logic                    prod_v, prod_last, sum_v, sum_last;

  for (genvar k = 0; k < NPAIR; k++) begin : g_mul
    localparam logic signed [COEF_W-1:0] CK = fir_sym_pkg::coef(k);
    assign term[k] = ACC_W'(pair[k]) * ACC_W'(CK);
  end

  always_comb begin
    sum_nxt = '0;
    for (int k = 0; k < NPAIR; k++) sum_nxt = sum_nxt + prod[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPAIR; k++) prod[k] <= '0;
      sum_q     <= '0;
      m_tdata   <= '0;
      prod_v    <= 1'b0;
      prod_last <= 1'b0;
      sum_v     <= 1'b0;
      sum_last  <= 1'b0;
      m_tvalid  <= 1'b0;
      m_tlast   <= 1'b0;
    end else if (adv) begin
      for (int k = 0; k < NPAIR; k++) prod[k] <= term[k];
      prod_v    <= in_v;
      prod_last <= in_last;
      sum_q     <= sum_nxt;
      sum_v     <= prod_v;
      sum_last  <= prod_last;
      m_tdata   <= round_clip(sum_q);
      m_tvalid  <= sum_v;
      m_tlast   <= sum_last;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  p_handoff_r5: assert property (@(posedge clk) disable iff (rst)
    (sum_v && adv) |=> m_tvalid);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
    m_tlast |-> m_tvalid);

endmodule

// File: rtl/fir_sym_stream.sv
module fir_sym_stream #(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 32,
  parameter int ACC_W  = 50,
  parameter int DROP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s_tvalid,
  input  logic signed [DATA_W-1:0] s_tdata,
  input  logic                     s_tlast,
  output logic                     s_tready,
  output logic                     m_tvalid,
  output logic signed [OUT_W-1:0]  m_tdata,
  output logic                     m_tlast,
  input  logic                     m_tready
);

  localparam int NTAPS  = fir_sym_pkg::NTAPS;
  localparam int NPAIR  = fir_sym_pkg::NPAIR;
  localparam int PAIR_W = DATA_W + 1;

  logic                     adv;
  logic                     in_fire;
  logic signed [DATA_W-1:0] taps [NTAPS];
  logic                     tap_v, tap_last;
  logic signed [PAIR_W-1:0] pair [NPAIR];
  logic                     pair_v, pair_last;

  // One enable for the whole pipeline: it moves unless the output is held.
  assign adv      = !m_tvalid || m_tready;
  assign s_tready = adv;
  assign in_fire  = s_tvalid && adv;

  fir_sym_taps #(.DATA_W(DATA_W), .NTAPS(NTAPS)) u_taps (
    .clk(clk), .rst(rst), .adv(adv), .in_fire(in_fire),
    .in_data(s_tdata), .in_last(s_tlast),
    .taps(taps), .out_v(tap_v), .out_last(tap_last)
  );

  fir_sym_preadd #(.DATA_W(DATA_W), .NTAPS(NTAPS), .NPAIR(NPAIR), .PAIR_W(PAIR_W)) u_pre (
    .clk(clk), .rst(rst), .adv(adv), .taps(taps),
    .in_v(tap_v), .in_last(tap_last),
    .pair(pair), .out_v(pair_v), .out_last(pair_last)
  );

  fir_sym_mac #(.PAIR_W(PAIR_W), .NPAIR(NPAIR), .ACC_W(ACC_W),
                .DROP_W(DROP_W), .OUT_W(OUT_W)) u_mac (
    .clk(clk), .rst(rst), .adv(adv), .pair(pair),
    .in_v(pair_v), .in_last(pair_last), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast)
  );

  // Checker state: samples accepted versus outputs delivered.
  logic [15:0] n_in, n_out;
  always_ff @(posedge clk) begin
    if (rst) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (in_fire)             n_in  <= n_in + 16'd1;
      if (m_tvalid && m_tready) n_out <= n_out + 16'd1;
    end
  end

  p_no_phantom_r9: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (n_in != n_out));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |-> !s_tready);

  p_full_rate_r2: assert property (@(posedge clk) disable iff (rst)
    m_tready |-> s_tready);

endmodule

// File: tb/fir_sym_stream_test.sv
module fir_sym_stream_test;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               s_tvalid = 1'b0;
  logic signed [31:0] s_tdata = '0;
  logic               s_tlast = 1'b0;
  logic               s_tready;
  logic               m_tvalid;
  logic signed [31:0] m_tdata;
  logic               m_tlast;
  logic               m_tready = 1'b1;

  always #4 clk = ~clk;

  fir_sym_stream uut (
    .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tdata(s_tdata),
    .s_tlast(s_tlast), .s_tready(s_tready), .m_tvalid(m_tvalid),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tready(m_tready)
  );

  int nchk = 0;
  int nfail = 0;
  int win = 0;
  int acc_win = -1;
  int first_out_win = -1;
  int r2_bad = 0;
  bit full_rate = 1'b0;
  bit logging = 1'b0;

  longint wt [27] = '{-255, -260, -312, -288, -144, 153, 616, 1233, 1963, 2739,
                      3474, 4081, 4481, 4620, 4481, 4081, 3474, 2739, 1963, 1233,
                      616, 153, -144, -288, -312, -260, -255};
  longint hist [27];
  longint q_d [$];
  bit     q_l [$];
  longint out_log [$];

  bit               prev_stall = 1'b0;
  logic signed [31:0] prev_data;
  logic             prev_last;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_out();
    longint y = 0;
    for (int k = 0; k < 27; k++) y += hist[k] * wt[k];
    y = (y + 32768) >>> 16;
    if (y > 64'sd2147483647) y = 64'sd2147483647;
    if (y < -64'sd2147483648) y = -64'sd2147483648;
    return y;
  endfunction

  task automatic observe();
    if (prev_stall)
      check(m_tvalid && m_tdata == prev_data && m_tlast == prev_last, "R6 hold",
            longint'(m_tdata), longint'(prev_data));
    if (m_tvalid && !m_tready)
      check(!s_tready, "R8 ready during stall", s_tready, 0);
    if (!m_tvalid)
      check(s_tready, "R8 ready when empty", s_tready, 1);
    if (full_rate && m_tready && !s_tready) r2_bad++;
    if (m_tvalid && m_tready) begin
      if (first_out_win < 0) first_out_win = win;
      if (q_d.size() == 0) begin
        check(1'b0, "R9 output without input", longint'(m_tdata), 0);
      end else begin
        longint e = q_d.pop_front();
        bit el = q_l.pop_front();
        check(longint'(m_tdata) == e, "R3 data", longint'(m_tdata), e);
        check(m_tlast == el, "R7 last", m_tlast, el);
        if (logging) out_log.push_back(longint'(m_tdata));
      end
    end
    if (s_tvalid && s_tready) begin
      if (acc_win < 0) acc_win = win;
      for (int k = 26; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(s_tdata);
      q_d.push_back(model_out());
      q_l.push_back(s_tlast);
    end
    prev_stall = m_tvalid && !m_tready;
    prev_data  = m_tdata;
    prev_last  = m_tlast;
  endtask

  task automatic step(input bit v, input logic signed [31:0] d, input bit l, input bit r);
    @(negedge clk);
    s_tvalid = v;
    s_tdata  = d;
    s_tlast  = l;
    m_tready = r;
    win++;
    #1;
    observe();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 27; k++) hist[k] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: empty output after reset
    check(!m_tvalid, "R1 valid after reset", m_tvalid, 0);

    // Impulse of 2^15: outputs are the weights halved, exercising R4 ties.
    logging = 1'b1;
    step(1'b1, 32'sd32768, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b1, 32'sd0, i == 29, 1'b1);
    repeat (8) step(1'b0, 32'sd0, 1'b0, 1'b1);
    logging = 1'b0;
    // R5: accepted in window acc_win, shown after 4 more edges
    check(first_out_win - acc_win == 5, "R5 latency", first_out_win - acc_win, 5);
    check(out_log.size() >= 27, "R9 impulse count", out_log.size(), 31);
    if (out_log.size() >= 27) begin
      check(out_log[0] == -127, "R4 -127.5 rounds up", out_log[0], -127);
      check(out_log[5] == 77, "R4 76.5 rounds up", out_log[5], 77);
      check(out_log[4] == -72, "R4 exact value", out_log[4], -72);
      for (int k = 0; k < 13; k++)
        check(out_log[k] == out_log[26-k], "R3 symmetric response", out_log[k], out_log[26-k]);
      // R1: nothing from before reset leaks after the impulse leaves
      check(out_log[27] == 0, "R1 zero history", out_log[27], 0);
    end

    // R2: full rate with ready held high
    full_rate = 1'b1;
    for (int i = 0; i < 200; i++) step(1'b1, $signed($urandom), ($urandom % 9) == 0, 1'b1);
    full_rate = 1'b0;
    check(r2_bad == 0, "R2 full rate", r2_bad, 0);

    // Extremes of the input range
    for (int i = 0; i < 30; i++) step(1'b1, 32'sh7FFFFFFF, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b1, 32'sh80000000, i == 29, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? 32'sh7FFFFFFF : 32'sh80000000, 1'b0, 1'b1);

    // R6/R8: long stall with input valid
    for (int i = 0; i < 20; i++) step(1'b1, $signed($urandom), 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b1, $signed($urandom), 1'b0, 1'b1);

    // Random valid and ready patterns
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $signed($urandom), ($urandom % 5) == 0, ($urandom % 3) != 0);

    // Drain and confirm every sample produced exactly one output (R9)
    for (int i = 0; i < 40; i++) step(1'b0, $signed($urandom), 1'b1, 1'b1);
    check(q_d.size() == 0, "R9 all delivered", q_d.size(), 0);
    check(!m_tvalid, "R9 idle after drain", m_tvalid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule